// File: doc/BRIEF.md
# Paired integer/FP issue stage

This block sits between instruction fetch and a two-lane in-order pipeline. Each fetch group is 64 bits wide and carries two 32-bit instructions. The upper half is the integer-side slot, meant for an ALU operation, a load, a store or a branch. The lower half is the FP slot, meant for a floating-point operation. The block holds the group in a one-entry buffer. Each cycle it decides whether nothing, the integer slot alone, the FP slot alone, or both slots go to execution.

Both slots leave together only when all of these hold:

- the pairing matches the slot types;
- the FP instruction does not read a result written by its partner;
- no instruction of the pair reads the destination of a load issued in the previous cycle.

When a pair cannot leave together, the integer slot goes first. The other instruction is kept and leaves alone before any new group is accepted, so program order is kept. A load leaves its result unusable by three instruction positions: its partner, and both members of the following pair.

Top module: `dual_issue_pair`

## Requirements
- R1: After reset, neither slot issues, `groupReady` is high, the buffer is empty and no load result is outstanding.
- R2: A group is taken at a rising edge where `groupValid` and `groupReady` are both high. Bits [63:32] form the integer slot and bits [31:0] form the FP slot. `groupReady` is high only when the buffer is empty or is being emptied in that cycle.
- R3: The instruction class sits in bits [31:29]: 0 ALU, 1 integer load, 2 FP load, 3 store, 4 branch, 5 FP operation, 6–7 no-op. The destination sits in [24:20], the first source in [19:15] and the second source in [14:10]. An FP operation reads and writes FP registers. An FP load writes an FP register. The other classes use integer registers; loads, stores and branches read the first source as an integer base.
- R4: A fresh pair issues both slots in the same cycle when the integer slot is not an FP operation, the FP slot is an FP operation, and no hazard of R7 or R8 applies. This includes an FP load paired with an independent FP operation.
- R5: The FP slot never issues in a cycle where the integer slot of the same group is still waiting and does not issue.
- R6: When the slot types do not pair (the FP slot holds a non-FP instruction, or the integer slot holds an FP operation), only the integer slot issues. The other instruction issues alone in the following cycle.
- R7: When the FP-slot instruction reads a register written by the integer-slot instruction of its own group, only the integer slot issues and the FP slot is held.
- R8: When an instruction waiting to issue reads the destination of a load issued in the previous cycle, nothing issues for exactly one cycle. This stalls the whole pair, and it also applies to a held FP-slot instruction.
- R9: Integer and FP registers are separate spaces, so a load to integer register n does not stall a reader of FP register n.
- R10: While a held instruction has not issued, no new group is accepted. The held instruction issues before any instruction of the next group.
- R11: `issueLeftInstr` and `issueRightInstr` carry the instruction of the corresponding slot whenever that slot issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| groupValid | input | 1 | Fetch offers a group |
| groupData | input | 64 | Fetch group: integer slot high, FP slot low |
| groupReady | output | 1 | Group is taken at this edge if valid |
| issueLeft | output | 1 | Integer-slot instruction issues this cycle |
| issueRight | output | 1 | FP-slot instruction issues this cycle |
| issueLeftInstr | output | 32 | Integer-slot instruction |
| issueRightInstr | output | 32 | FP-slot instruction |

## Verification
A group offered before a rising edge is in the buffer after that edge. Its issue decision, and the new value of `groupReady`, can be seen from that same edge onward, because both are combinational on the buffer and on the outstanding-load state. Each later issue of a held slot, and the single stall cycle after a load, appears one edge later per step. The bench drives and samples only at falling edges and writes out, cycle by cycle, the issue bits, ready and instruction words each scenario expects. Back-to-back groups are offered while the previous group is still draining, so that acceptance blocking and load stalls land in the cycles the requirements predict.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  localparam int INSTR_W = 32;
  localparam int GROUP_W = 2 * INSTR_W;
  localparam int REG_W   = 5;
  localparam int CLS_W   = 3;
  localparam int CLS_LO  = INSTR_W - CLS_W;
  localparam int RD_LO   = 20;
  localparam int RS1_LO  = 15;
  localparam int RS2_LO  = 10;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU  = 3'd0,
    CLS_LDI  = 3'd1,
    CLS_LDF  = 3'd2,
    CLS_ST   = 3'd3,
    CLS_BR   = 3'd4,
    CLS_FOP  = 3'd5,
    CLS_NOP6 = 3'd6,
    CLS_NOP7 = 3'd7
  } instrCls_e;

  typedef struct packed {
    logic             en;
    logic             fp;
    logic [REG_W-1:0] idx;
  } regRef_t;

  typedef struct packed {
    logic    isFpOp;
    logic    isLoad;
    regRef_t wr;
    regRef_t rd1;
    regRef_t rd2;
  } decInfo_t;

  typedef struct packed {
    logic issueLeft;
    logic issueRight;
    logic loadGroup;
  } issueStrobe_t;

  function automatic logic refHit(regRef_t a, regRef_t b);
    return a.en && b.en && (a.fp == b.fp) && (a.idx == b.idx);
  endfunction
endpackage

// File: rtl/dual_issue_decode.sv
module dual_issue_decode
  import dual_issue_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output decInfo_t           info
);
  instrCls_e        cls;
  logic [REG_W-1:0] rd, rs1, rs2;

  assign cls = instrCls_e'(instr[CLS_LO +: CLS_W]);
  assign rd  = instr[RD_LO  +: REG_W];
  assign rs1 = instr[RS1_LO +: REG_W];
  assign rs2 = instr[RS2_LO +: REG_W];

  always_comb begin
    info = '0;
    info.wr.idx  = rd;
    info.rd1.idx = rs1;
    info.rd2.idx = rs2;
    unique case (cls)
      CLS_ALU: begin
        info.wr.en  = 1'b1;
        info.rd1.en = 1'b1;
        info.rd2.en = 1'b1;
      end
      CLS_LDI: begin
        info.isLoad = 1'b1;
        info.wr.en  = 1'b1;
        info.rd1.en = 1'b1;
      end
      CLS_LDF: begin
        info.isLoad = 1'b1;
        info.wr.en  = 1'b1;
        info.wr.fp  = 1'b1;
        info.rd1.en = 1'b1;
      end
      CLS_ST: begin
        info.rd1.en = 1'b1;
        info.rd2.en = 1'b1;
      end
      CLS_BR: begin
        info.rd1.en = 1'b1;
      end
      CLS_FOP: begin
        info.isFpOp = 1'b1;
        info.wr.en  = 1'b1;
        info.wr.fp  = 1'b1;
        info.rd1.en = 1'b1;
        info.rd1.fp = 1'b1;
        info.rd2.en = 1'b1;
        info.rd2.fp = 1'b1;
      end
      default: info.wr.en = 1'b0;
    endcase
  end
endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
  import dual_issue_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         groupValid,
  input  logic         leftPend,
  input  logic         rightPend,
  input  decInfo_t     leftInfo,
  input  decInfo_t     rightInfo,
  input  regRef_t      loadRef,
  output issueStrobe_t strobe,
  output logic         groupReady
);
  logic hazLeft, hazRight, stall, intraDep, typesPair, canPair;

  assign hazLeft  = leftPend  && (refHit(leftInfo.rd1, loadRef)  || refHit(leftInfo.rd2, loadRef));
  assign hazRight = rightPend && (refHit(rightInfo.rd1, loadRef) || refHit(rightInfo.rd2, loadRef));
  assign stall    = hazLeft || hazRight;

  assign intraDep  = refHit(leftInfo.wr, rightInfo.rd1) || refHit(leftInfo.wr, rightInfo.rd2);
  assign typesPair = rightInfo.isFpOp && !leftInfo.isFpOp;
  assign canPair   = typesPair && !intraDep;

  always_comb begin
    strobe            = '0;
    strobe.issueLeft  = leftPend && !stall;
    strobe.issueRight = rightPend && !stall && (!leftPend || canPair);
    groupReady        = !(leftPend || rightPend) || strobe.issueRight;
    strobe.loadGroup  = groupValid && groupReady;
  end

  // R5: the FP slot never overtakes its own integer slot
  a_r5_right_needs_left: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueRight && leftPend) |-> strobe.issueLeft);

  // R8: a load-use stall lasts one cycle only
  a_r8_stall_once: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  // R4: a dual issue always pairs a non-FP op with an FP op
  a_r4_pair_kinds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueLeft && strobe.issueRight) |-> (rightInfo.isFpOp && !leftInfo.isFpOp));
endmodule

// File: rtl/dual_issue_dp.sv
module dual_issue_dp
  import dual_issue_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [GROUP_W-1:0] groupData,
  input  issueStrobe_t       strobe,
  input  decInfo_t           leftInfo,
  input  decInfo_t           rightInfo,
  output logic [INSTR_W-1:0] leftInstr,
  output logic [INSTR_W-1:0] rightInstr,
  output logic               leftPend,
  output logic               rightPend,
  output regRef_t            loadRef
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftInstr  <= '0;
      rightInstr <= '0;
      leftPend   <= 1'b0;
      rightPend  <= 1'b0;
      loadRef    <= '0;
    end else begin
      if (strobe.loadGroup) begin
        leftInstr  <= groupData[GROUP_W-1:INSTR_W];
        rightInstr <= groupData[INSTR_W-1:0];
        leftPend   <= 1'b1;
        rightPend  <= 1'b1;
      end else begin
        if (strobe.issueLeft)  leftPend  <= 1'b0;
        if (strobe.issueRight) rightPend <= 1'b0;
      end
      if (strobe.issueLeft && leftInfo.isLoad)        loadRef <= leftInfo.wr;
      else if (strobe.issueRight && rightInfo.isLoad) loadRef <= rightInfo.wr;
      else                                            loadRef <= '0;
    end
  end

  // R2: an accepted group fills both slots
  a_r2_group_loaded: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadGroup |=> (leftPend && rightPend && leftInstr == $past(groupData[GROUP_W-1:INSTR_W])));

  // R10: a held FP-slot instruction stays put until it issues
  a_r10_held_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rightPend && !leftPend && !strobe.issueRight) |=> (rightPend && $stable(rightInstr)));

  // R8: nothing issues while reading the previous cycle's load result
  a_r8_no_early_use: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueLeft |-> !(refHit(leftInfo.rd1, loadRef) || refHit(leftInfo.rd2, loadRef)));
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dual_issue_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               groupValid,
  input  logic [GROUP_W-1:0] groupData,
  output logic               groupReady,
  output logic               issueLeft,
  output logic               issueRight,
  output logic [INSTR_W-1:0] issueLeftInstr,
  output logic [INSTR_W-1:0] issueRightInstr
);
  issueStrobe_t       strobe;
  logic [INSTR_W-1:0] slotInstr [2];
  decInfo_t           slotInfo  [2];
  logic               leftPend, rightPend;
  regRef_t            loadRef;

  for (genvar s = 0; s < 2; s++) begin : g_slot
    dual_issue_decode u_dec (.instr(slotInstr[s]), .info(slotInfo[s]));
  end

  dual_issue_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .groupValid(groupValid),
    .leftPend(leftPend), .rightPend(rightPend),
    .leftInfo(slotInfo[0]), .rightInfo(slotInfo[1]), .loadRef(loadRef),
    .strobe(strobe), .groupReady(groupReady)
  );

  dual_issue_dp u_dp (
    .clk(clk), .rstN(rstN), .groupData(groupData), .strobe(strobe),
    .leftInfo(slotInfo[0]), .rightInfo(slotInfo[1]),
    .leftInstr(slotInstr[0]), .rightInstr(slotInstr[1]),
    .leftPend(leftPend), .rightPend(rightPend), .loadRef(loadRef)
  );

  assign issueLeft       = strobe.issueLeft;
  assign issueRight      = strobe.issueRight;
  assign issueLeftInstr  = slotInstr[0];
  assign issueRightInstr = slotInstr[1];
endmodule

// File: tb/dual_issue_pair_bench.sv
module dual_issue_pair_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        groupValid = 1'b0;
  logic [63:0] groupData = '0;
  logic        groupReady, issueLeft, issueRight;
  logic [31:0] issueLeftInstr, issueRightInstr;
  int          total = 0;
  int          failed = 0;
  int          cycles = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  dual_issue_pair u_dual_issue_pair (
    .clk(clk), .rstN(rstN), .groupValid(groupValid), .groupData(groupData),
    .groupReady(groupReady), .issueLeft(issueLeft), .issueRight(issueRight),
    .issueLeftInstr(issueLeftInstr), .issueRightInstr(issueRightInstr)
  );

  // R3 encoding: class [31:29], rd [24:20], rs1 [19:15], rs2 [14:10]
  function automatic logic [31:0] mk(logic [2:0] c, int rd, int rs1, int rs2);
    logic [4:0] a = rd[4:0];
    logic [4:0] b = rs1[4:0];
    logic [4:0] d = rs2[4:0];
    return {c, 4'b0, a, b, d, 10'b0};
  endfunction

  localparam logic [2:0] ALU = 3'd0, LDI = 3'd1, LDF = 3'd2, FOP = 3'd5;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic expL, logic expR, logic expRdy);
    total++;
    if (issueLeft !== expL || issueRight !== expR || groupReady !== expRdy) begin
      failed++;
      $display("FAIL %s: left/right/ready got %b%b%b expected %b%b%b",
               tag, issueLeft, issueRight, groupReady, expL, expR, expRdy);
    end
  endtask

  task automatic checkWord(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s: instr got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic [31:0] l, logic [31:0] r);
    groupValid = 1'b1;
    groupData  = {l, r};
  endtask

  task automatic idle();
    groupValid = 1'b0;
    groupData  = '0;
  endtask

  task automatic settle();
    idle(); tick(); tick();
  endtask

  task automatic testReset();
    check("R1 reset", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testPair();
    logic [31:0] l = mk(ALU, 3, 1, 2);
    logic [31:0] r = mk(FOP, 4, 5, 6);
    drive(l, r); tick();
    check("R4 ALU+FOP pair", 1'b1, 1'b1, 1'b1);
    checkWord("R11 left word", issueLeftInstr, l);
    checkWord("R11 right word", issueRightInstr, r);
    checkWord("R2 right half", issueRightInstr, r);
    idle(); tick();
    check("R2 empty after pair", 1'b0, 1'b0, 1'b1);
    settle();
  endtask

  task automatic testSplitTypes();
    drive(mk(ALU, 3, 1, 2), mk(ALU, 7, 8, 9)); tick();
    check("R6 non-FP right: left only", 1'b1, 1'b0, 1'b0);
    idle(); tick();
    check("R6 right alone next", 1'b0, 1'b1, 1'b1);
    tick();
    check("R6 drained", 1'b0, 1'b0, 1'b1);
    settle();
    drive(mk(FOP, 1, 2, 3), mk(FOP, 4, 5, 6)); tick();
    check("R6 FP left: left only", 1'b1, 1'b0, 1'b0);
    idle(); tick();
    check("R6 FP right alone next", 1'b0, 1'b1, 1'b1);
    settle();
  endtask

  task automatic testIntraDep();
    drive(mk(LDF, 3, 1, 0), mk(FOP, 4, 3, 6)); tick();
    check("R7 dependent right held", 1'b1, 1'b0, 1'b0);
    idle(); tick();
    check("R8 held right stalls on load", 1'b0, 1'b0, 1'b0);
    tick();
    check("R8 held right issues after delay", 1'b0, 1'b1, 1'b1);
    settle();
  endtask

  task automatic testFpLoadNextPair();
    drive(mk(LDF, 3, 1, 0), mk(FOP, 4, 5, 6)); tick();
    check("R4 FP load + FP op pair", 1'b1, 1'b1, 1'b1);
    drive(mk(ALU, 9, 1, 2), mk(FOP, 7, 3, 8)); tick();
    check("R8 next pair FP use stalls", 1'b0, 1'b0, 1'b0);
    idle(); tick();
    check("R8 pair issues after stall", 1'b1, 1'b1, 1'b1);
    settle();
  endtask

  task automatic testIntLoadNextPair();
    drive(mk(LDI, 5, 1, 0), mk(FOP, 6, 7, 8)); tick();
    check("R4 int load + FP op pair", 1'b1, 1'b1, 1'b1);
    drive(mk(ALU, 9, 5, 2), mk(FOP, 10, 11, 12)); tick();
    check("R8 int use stalls pair", 1'b0, 1'b0, 1'b0);
    idle(); tick();
    check("R8 int pair after stall", 1'b1, 1'b1, 1'b1);
    settle();
  endtask

  task automatic testSpaces();
    drive(mk(LDI, 5, 1, 0), mk(FOP, 6, 7, 8)); tick();
    check("R9 load pair", 1'b1, 1'b1, 1'b1);
    drive(mk(ALU, 9, 1, 2), mk(FOP, 10, 5, 5)); tick();
    check("R9 FP reg 5 not stalled by int reg 5", 1'b1, 1'b1, 1'b1);
    settle();
  endtask

  task automatic testOrder();
    logic [31:0] aR = mk(ALU, 7, 8, 9);
    logic [31:0] bL = mk(ALU, 11, 12, 13);
    drive(mk(ALU, 3, 1, 2), aR); tick();
    check("R10 first group split", 1'b1, 1'b0, 1'b0);
    drive(bL, mk(FOP, 14, 15, 16)); tick();
    check("R10 held right before next group", 1'b0, 1'b1, 1'b1);
    checkWord("R10 held word issues", issueRightInstr, aR);
    tick();
    check("R10 next group after held", 1'b1, 1'b1, 1'b1);
    checkWord("R11 next left word", issueLeftInstr, bL);
    settle();
  endtask

  initial begin
    tick(); tick();
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testPair();
    testSplitTypes();
    testIntraDep();
    testFpLoadNextPair();
    testIntLoadNextPair();
    testSpaces();
    testOrder();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      finished = 1'b1;
      total++;
      failed++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule